// File: doc/BRIEF.md
# Row-Cached DRAM Bank Model

A cycle-accurate, synthesizable model of a single DRAM bank fitted with a one-row cache register. The array side tracks the open page and its timing windows: activate-to-access delay, the precharge window and the refresh window. A read that takes its data from the array copies the entire open row into the cache. The burst is then assembled from that copy, which leaves the array free. It can be precharged, refreshed or re-activated while earlier words are still being driven out.

Any read whose row matches the cache tag is served from the cache, whether the page is closed or another row is open. A write to the open row updates the array. If the cache holds that same row, the write updates the cache too.

Read data appears after a CAS latency of 2 as a burst of 4 words. Two sticky flags are provided. One reports commands issued too early. The other reports accesses to a row that is neither open nor cached.

Top module: `rc_dram_bank`

## Requirements
- R1: After reset, rvalid_o, timing_err_o, miss_err_o and bank_open_o are 0, every array word is 0 and the cache is invalid.
- R2: Command codes on cmd_i are NOP=0, ACT=1, RD=2, RDA=3, WR=4, PRE=5, REF=6. An ACT on an idle bank opens row_i. An RD or WR to that row sampled fewer than 2 cycles after the ACT is ignored and sets timing_err_o.
- R3: A read accepted at clock edge k drives rvalid_o high at edges k+2 through k+5. The words come from columns col_i, col_i+1, col_i+2 and col_i+3, wrapping inside the aligned group of 4 columns.
- R4: A read served from the array copies the whole row into the cache. A later read to the cached row is served from the cache, without error, while the page is closed.
- R5: An RDA served from the array closes the page at once, and precharge starts one cycle later. An ACT is accepted 3 cycles after the RDA. An earlier ACT sets timing_err_o.
- R6: A PRE closes the open page. An ACT is accepted 2 cycles after the PRE. An earlier ACT sets timing_err_o.
- R7: A REF is accepted only on a closed, idle bank, and it keeps the bank busy for 4 cycles. A REF issued while a burst is in progress leaves the burst words unchanged.
- R8: A WR to the open row, once the activate delay has passed, writes the array word. If the cache holds that row, the same cache word is also written.
- R9: Two cases are ignored and set miss_err_o, which stays set until reset: a read to a row that is neither open nor cached, and a WR to a row that is not open.
- R10: Two cases are ignored and set timing_err_o, which stays set until reset: an ACT while the bank is open, precharging or refreshing, and a REF when the bank is not idle.
- R11: A PRE, ACT or WR issued after a read has been accepted does not change that read's burst words.
- R12: Reads accepted 4 cycles apart produce back-to-back bursts with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| row_i | input | ROW_W | Row address |
| col_i | input | COL_W | Starting column of the burst, or the write column |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read burst word |
| rvalid_o | output | 1 | rdata_o holds a burst word |
| bank_open_o | output | 1 | A page is open in the array |
| timing_err_o | output | 1 | Sticky flag for a command issued too early |
| miss_err_o | output | 1 | Sticky flag for an access to a row that is neither open nor cached |

## Verification
The bench issues a refresh, a precharge, an activate and a write while a cache burst is still being driven out. A design that streamed from the array, or that held no snapshot of the burst, would output the new or cleared data in place of the words captured at the read. Two reads are placed exactly one burst apart, which catches a pipeline that drops or repeats a word at the join. An ACT is issued one cycle early after PRE, after RDA and after REF, which exposes counters that are off by one or that fail to apply the extra cycle for auto-precharge. A write to a cached row is followed by a cache-hit read with the page closed, which reports stale data if the cache is not kept coherent.

// File: rtl/rc_dram_pkg.sv
package rc_dram_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5,
    CMD_REF = 3'd6
  } cmd_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rc_dram_timer.sv
module rc_dram_timer #(
  parameter int ROW_W = 3,
  parameter int T_RCD = 2,
  parameter int T_RP  = 2,
  parameter int T_RFC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [ROW_W-1:0] act_row_i,
  input  logic             pre_i,
  input  logic             auto_pre_i,
  input  logic             ref_i,
  output logic             open_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             rcd_ok_o,
  output logic             idle_o
);
  localparam int TMAX  = rc_dram_pkg::max3(T_RCD, T_RP + 1, T_RFC);
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  // auto-precharge starts one cycle after the read
  localparam logic [CNT_W-1:0] RPA_LD = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, rp_q, rfc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      rp_q   <= '0;
      rfc_q  <= '0;
    end else begin
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (rp_q  != '0) rp_q  <= rp_q - 1'b1;
      if (rfc_q != '0) rfc_q <= rfc_q - 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= act_row_i;
        rcd_q  <= RCD_LD;
      end else if (auto_pre_i) begin
        open_q <= 1'b0;
        rp_q   <= RPA_LD;
      end else if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= RP_LD;
      end else if (ref_i) begin
        rfc_q  <= RFC_LD;
      end
    end
  end

  assign open_o     = open_q;
  assign open_row_o = row_q;
  assign rcd_ok_o   = (rcd_q == '0);
  assign idle_o     = !open_q && (rp_q == '0) && (rfc_q == '0);
endmodule

// File: rtl/rc_dram_array.sv
module rc_dram_array #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [ROW_W-1:0]             wr_row_i,
  input  logic [COL_W-1:0]             wr_col_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  input  logic [ROW_W-1:0]             rd_row_i,
  output logic [(1<<COL_W)-1:0][DATA_W-1:0] rd_line_o
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [COLS-1:0][DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (wr_i) begin
      mem_q[wr_row_i][wr_col_i] <= wr_data_i;
    end
  end

  assign rd_line_o = mem_q[rd_row_i];
endmodule

// File: rtl/rc_dram_cache.sv
module rc_dram_cache #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [ROW_W-1:0]             load_tag_i,
  input  logic [(1<<COL_W)-1:0][DATA_W-1:0] load_line_i,
  input  logic                         wr_i,
  input  logic [ROW_W-1:0]             wr_row_i,
  input  logic [COL_W-1:0]             wr_col_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic                         valid_o,
  output logic [ROW_W-1:0]             tag_o,
  output logic [(1<<COL_W)-1:0][DATA_W-1:0] line_o
);
  localparam int COLS = 1 << COL_W;

  logic                        valid_q;
  logic [ROW_W-1:0]            tag_q;
  logic [COLS-1:0][DATA_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      line_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      tag_q   <= load_tag_i;
      line_q  <= load_line_i;
    end else if (wr_i && valid_q && (tag_q == wr_row_i)) begin
      line_q[wr_col_i] <= wr_data_i;  // keep coherent with array
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign line_o  = line_q;
endmodule

// File: rtl/rc_dram_burst.sv
module rc_dram_burst #(
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int BL     = 4,
  parameter int CL     = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         launch_i,
  input  logic [COL_W-1:0]             col_i,
  input  logic [(1<<COL_W)-1:0][DATA_W-1:0] line_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         rvalid_o
);
  localparam int DEPTH = CL + BL - 1;
  localparam logic [COL_W-1:0] WRAP_M = COL_W'(BL - 1);

  logic [DEPTH-1:0]             vld_q, vld_d;
  logic [DEPTH-1:0][DATA_W-1:0] dat_q, dat_d;

  function automatic logic [COL_W-1:0] beat_col(int b);
    return (col_i & ~WRAP_M) | ((col_i + COL_W'(b)) & WRAP_M);
  endfunction

  // words are snapshotted at launch; later array/cache changes cannot reach them
  always_comb begin
    vld_d = '0;
    dat_d = '0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      vld_d[i] = vld_q[i+1];
      dat_d[i] = dat_q[i+1];
    end
    if (launch_i) begin
      for (int b = 0; b < BL; b++) begin
        vld_d[CL-1+b] = 1'b1;
        dat_d[CL-1+b] = line_i[beat_col(b)];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      dat_q <= dat_d;
    end
  end

  assign rvalid_o = vld_q[0];
  assign rdata_o  = dat_q[0];
endmodule

// File: rtl/rc_dram_bank.sv
module rc_dram_bank
  import rc_dram_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 16,
  parameter int BL     = 4,
  parameter int CL     = 2,
  parameter int T_RCD  = 2,
  parameter int T_RP   = 2,
  parameter int T_RFC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cmd_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              bank_open_o,
  output logic              timing_err_o,
  output logic              miss_err_o
);
  localparam int COLS = 1 << COL_W;

  cmd_e cmd;
  logic is_rd, is_wr, is_act, is_pre, is_ref, is_rda;
  logic open, rcd_ok, idle;
  logic [ROW_W-1:0] open_row;
  logic page_hit, cache_hit;
  logic rd_arr, rd_go, wr_go, act_go, pre_go, apre_go, ref_go;
  logic t_viol, m_viol;
  logic c_valid;
  logic [ROW_W-1:0] c_tag;
  logic [COLS-1:0][DATA_W-1:0] arr_line, c_line, src_line;
  logic terr_q, merr_q;

  assign cmd    = cmd_e'(cmd_i);
  assign is_rda = (cmd == CMD_RDA);
  assign is_rd  = (cmd == CMD_RD) || is_rda;
  assign is_wr  = (cmd == CMD_WR);
  assign is_act = (cmd == CMD_ACT);
  assign is_pre = (cmd == CMD_PRE);
  assign is_ref = (cmd == CMD_REF);

  assign page_hit  = open && (open_row == row_i);
  assign cache_hit = c_valid && (c_tag == row_i);

  assign rd_arr  = is_rd && page_hit && rcd_ok;
  assign rd_go   = rd_arr || (is_rd && cache_hit);
  assign wr_go   = is_wr && page_hit && rcd_ok;
  assign act_go  = is_act && idle;
  assign pre_go  = is_pre && open;
  assign apre_go = is_rda && rd_arr;
  assign ref_go  = is_ref && idle;

  assign t_viol = (is_act && !idle) || (is_ref && !idle)
               || (is_rd && page_hit && !rcd_ok && !cache_hit)
               || (is_wr && page_hit && !rcd_ok);
  assign m_viol = (is_rd && !page_hit && !cache_hit) || (is_wr && !page_hit);

  assign src_line = rd_arr ? arr_line : c_line;

  rc_dram_timer #(
    .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act_go),
    .act_row_i  (row_i),
    .pre_i      (pre_go),
    .auto_pre_i (apre_go),
    .ref_i      (ref_go),
    .open_o     (open),
    .open_row_o (open_row),
    .rcd_ok_o   (rcd_ok),
    .idle_o     (idle)
  );

  rc_dram_array #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_go),
    .wr_row_i  (open_row),
    .wr_col_i  (col_i),
    .wr_data_i (wdata_i),
    .rd_row_i  (open_row),
    .rd_line_o (arr_line)
  );

  rc_dram_cache #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (rd_arr),
    .load_tag_i  (open_row),
    .load_line_i (arr_line),
    .wr_i        (wr_go),
    .wr_row_i    (open_row),
    .wr_col_i    (col_i),
    .wr_data_i   (wdata_i),
    .valid_o     (c_valid),
    .tag_o       (c_tag),
    .line_o      (c_line)
  );

  rc_dram_burst #(
    .COL_W(COL_W), .DATA_W(DATA_W), .BL(BL), .CL(CL)
  ) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (rd_go),
    .col_i    (col_i),
    .line_i   (src_line),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      terr_q <= 1'b0;
      merr_q <= 1'b0;
    end else begin
      if (t_viol) terr_q <= 1'b1;
      if (m_viol) merr_q <= 1'b1;
    end
  end

  assign bank_open_o  = open;
  assign timing_err_o = terr_q;
  assign miss_err_o   = merr_q;
endmodule

// File: rtl/rc_dram_bank_chk.sv
module rc_dram_bank_chk
  import rc_dram_pkg::*;
#(
  parameter int ROW_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       cmd_i,
  input logic [ROW_W-1:0] row_i,
  input logic             bank_open_o,
  input logic             timing_err_o,
  input logic             miss_err_o,
  input logic             c_valid,
  input logic [ROW_W-1:0] c_tag
);
  logic rd_cmd;
  assign rd_cmd = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA);

  p_terr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_err_o |=> timing_err_o);

  p_miss_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_err_o |=> miss_err_o);

  p_act_while_open_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ACT && bank_open_o) |=> timing_err_o);

  p_pre_closes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_PRE) |=> !bank_open_o);

  p_cold_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && !bank_open_o && !c_valid) |=> miss_err_o);

  p_cache_hit_no_miss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cmd && c_valid && c_tag == row_i) |=> $stable(miss_err_o));
endmodule

bind rc_dram_bank rc_dram_bank_chk #(.ROW_W(ROW_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_i        (cmd_i),
  .row_i        (row_i),
  .bank_open_o  (bank_open_o),
  .timing_err_o (timing_err_o),
  .miss_err_o   (miss_err_o),
  .c_valid      (c_valid),
  .c_tag        (c_tag)
);

// File: tb/rc_dram_bank_tb.sv
`timescale 1ns/1ps
module rc_dram_bank_tb;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, RDA = 3'd3,
                         WR = 3'd4, PRE = 3'd5, REF = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd = NOP;
  logic [2:0]  row = '0;
  logic [2:0]  col = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        rvalid, bopen, terr, merr;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rc_dram_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .row_i(row), .col_i(col),
    .wdata_i(wd), .rdata_o(rdata), .rvalid_o(rvalid), .bank_open_o(bopen),
    .timing_err_o(terr), .miss_err_o(merr)
  );

  typedef struct packed {
    logic [2:0]  c;
    logic [2:0]  r;
    logic [2:0]  k;
    logic [15:0] w;
    logic        v;
    logic [15:0] d;
    logic [3:0]  req;
  } vec_t;

  // expected rvalid/rdata are the outputs seen just after this cycle's edge
  localparam vec_t VEC [34] = '{
    '{ACT, 3'd1, 3'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 0  R2 open row 1
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b0, 16'h0000, 4'd2},  // 1
    '{WR,  3'd1, 3'd0, 16'h1100, 1'b0, 16'h0000, 4'd8},  // 2  R8
    '{WR,  3'd1, 3'd1, 16'h1101, 1'b0, 16'h0000, 4'd8},  // 3
    '{WR,  3'd1, 3'd2, 16'h1102, 1'b0, 16'h0000, 4'd8},  // 4
    '{WR,  3'd1, 3'd3, 16'h1103, 1'b0, 16'h0000, 4'd8},  // 5
    '{RDA, 3'd1, 3'd1, 16'h0000, 1'b0, 16'h0000, 4'd5},  // 6  R5 R3 wrap
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1101, 4'd3},  // 7
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1102, 4'd3},  // 8
    '{ACT, 3'd2, 3'd0, 16'h0000, 1'b1, 16'h1103, 4'd11}, // 9  R11 hidden ACT
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1100, 4'd3},  // 10
    '{WR,  3'd2, 3'd4, 16'h2204, 1'b0, 16'h0000, 4'd8},  // 11
    '{WR,  3'd2, 3'd5, 16'h2205, 1'b0, 16'h0000, 4'd8},  // 12
    '{WR,  3'd2, 3'd6, 16'h2206, 1'b0, 16'h0000, 4'd8},  // 13
    '{WR,  3'd2, 3'd7, 16'h2207, 1'b0, 16'h0000, 4'd8},  // 14
    '{RD,  3'd2, 3'd6, 16'h0000, 1'b0, 16'h0000, 4'd4},  // 15 R4 loads cache
    '{PRE, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h2206, 4'd11}, // 16 R11
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h2207, 4'd3},  // 17
    '{REF, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h2204, 4'd7},  // 18 R7 hidden refresh
    '{RD,  3'd2, 3'd4, 16'h0000, 1'b1, 16'h2205, 4'd12}, // 19 R12 R4 hit closed
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h2204, 4'd12}, // 20
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h2205, 4'd4},  // 21
    '{ACT, 3'd1, 3'd0, 16'h0000, 1'b1, 16'h2206, 4'd7},  // 22 R7 refresh done
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h2207, 4'd4},  // 23
    '{RD,  3'd1, 3'd3, 16'h0000, 1'b0, 16'h0000, 4'd3},  // 24
    '{WR,  3'd1, 3'd0, 16'h5A5A, 1'b1, 16'h1103, 4'd11}, // 25 R11 R8
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1100, 4'd11}, // 26 old word kept
    '{PRE, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1101, 4'd6},  // 27
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1102, 4'd3},  // 28
    '{RD,  3'd1, 3'd0, 16'h0000, 1'b0, 16'h0000, 4'd8},  // 29 R8 coherent hit
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h5A5A, 4'd8},  // 30
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1101, 4'd3},  // 31
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1102, 4'd3},  // 32
    '{NOP, 3'd0, 3'd0, 16'h0000, 1'b1, 16'h1103, 4'd3}   // 33
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [2:0] r, input logic [2:0] k,
                      input logic [15:0] w);
    @(negedge clk);
    cmd = c; row = r; col = k; wd = w;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd = NOP; row = '0; col = '0; wd = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk("R1 rvalid", 32'(rvalid), 32'd0);
    chk("R1 bank_open", 32'(bopen), 32'd0);
    chk("R1 timing_err", 32'(terr), 32'd0);
    chk("R1 miss_err", 32'(merr), 32'd0);

    for (int i = 0; i < 34; i++) begin
      step(VEC[i].c, VEC[i].r, VEC[i].k, VEC[i].w);
      n_chk++;
      if (rvalid !== VEC[i].v || (VEC[i].v && rdata !== VEC[i].d) || terr || merr) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual v=%0b d=%0h te=%0b me=%0b expected v=%0b d=%0h",
                 VEC[i].req, i, rvalid, rdata, terr, merr, VEC[i].v, VEC[i].d);
      end
    end

    // R1 cache invalid and array zero after reset
    do_reset();
    step(RD, 3'd0, 3'd0, 16'h0);
    chk("R1 cold read miss", 32'(merr), 32'd1);
    step(NOP, 3'd0, 3'd0, 16'h0);
    chk("R9 miss read ignored", 32'(rvalid), 32'd0);
    do_reset();
    step(ACT, 3'd5, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(RD, 3'd5, 3'd2, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    chk("R1 array zero valid", 32'(rvalid), 32'd1);
    chk("R1 array zero data", 32'(rdata), 32'd0);

    // R2 read too soon after ACT
    do_reset();
    step(ACT, 3'd3, 3'd0, 16'h0);
    chk("R2 bank_open", 32'(bopen), 32'd1);
    step(RD, 3'd3, 3'd0, 16'h0);
    chk("R2 early read timing_err", 32'(terr), 32'd1);
    step(NOP, 3'd0, 3'd0, 16'h0);
    chk("R2 early read ignored", 32'(rvalid), 32'd0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    chk("R2 early read ignored", 32'(rvalid), 32'd0);

    // R10 ACT while open ignored, original row stays open
    do_reset();
    step(ACT, 3'd1, 3'd0, 16'h0);
    step(ACT, 3'd2, 3'd0, 16'h0);
    chk("R10 act while open", 32'(terr), 32'd1);
    step(WR, 3'd1, 3'd0, 16'hBEEF);
    chk("R10 row kept", 32'(merr), 32'd0);
    step(RD, 3'd1, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    chk("R10 row kept data", 32'(rdata), 32'hBEEF);
    step(NOP, 3'd0, 3'd0, 16'h0);
    chk("R10 sticky", 32'(terr), 32'd1);

    // R5 auto-precharge timing
    do_reset();
    step(ACT, 3'd0, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(RDA, 3'd0, 3'd0, 16'h0);
    chk("R5 page closed", 32'(bopen), 32'd0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(ACT, 3'd0, 3'd0, 16'h0);
    chk("R5 early act", 32'(terr), 32'd1);
    do_reset();
    step(ACT, 3'd0, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(RDA, 3'd0, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(ACT, 3'd4, 3'd0, 16'h0);
    chk("R5 act accepted err", 32'(terr), 32'd0);
    chk("R5 act accepted open", 32'(bopen), 32'd1);

    // R6 precharge timing
    do_reset();
    step(ACT, 3'd0, 3'd0, 16'h0);
    step(PRE, 3'd0, 3'd0, 16'h0);
    chk("R6 pre closes", 32'(bopen), 32'd0);
    step(ACT, 3'd0, 3'd0, 16'h0);
    chk("R6 early act", 32'(terr), 32'd1);
    do_reset();
    step(ACT, 3'd0, 3'd0, 16'h0);
    step(PRE, 3'd0, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(ACT, 3'd0, 3'd0, 16'h0);
    chk("R6 act accepted", 32'(terr), 32'd0);

    // R7 refresh busy window
    do_reset();
    step(REF, 3'd0, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(ACT, 3'd0, 3'd0, 16'h0);
    chk("R7 act during refresh", 32'(terr), 32'd1);
    do_reset();
    step(ACT, 3'd0, 3'd0, 16'h0);
    step(REF, 3'd0, 3'd0, 16'h0);
    chk("R10 ref while open", 32'(terr), 32'd1);

    // R9 write to a row that is not open
    do_reset();
    step(ACT, 3'd1, 3'd0, 16'h0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    step(WR, 3'd2, 3'd0, 16'h1234);
    chk("R9 write miss", 32'(merr), 32'd1);
    chk("R9 write miss no timing", 32'(terr), 32'd0);
    step(NOP, 3'd0, 3'd0, 16'h0);
    chk("R9 sticky", 32'(merr), 32'd1);

    finish_run();
  end
endmodule